// File: doc/BRIEF.md
# Six-Channel Serial Result Output Mux

This block sits at the digital edge of a six-channel sampling converter. It keeps the latest six 16-bit results, named A0, A1, B0, B1, C0 and C1, and sends them out serially during a frame. A frame opens when the frame-sync input falls and closes when it rises. Up to three data lanes carry the words: lane A, lane B and lane C. Each lane has a data bit and an output-enable bit, and together they drive an external tri-state pad.

Two straps switch lanes B and C on or off. When a lane is switched off, its words move onto the lanes that are still on, so one, two or three lanes can carry all six results. A daisy-chain option appends the bits that arrive on a per-lane chain input behind the local words. This lets several devices share one set of lanes.

Every input is sampled on the block clock `clk`. The serial clock and frame sync must be slow against `clk`, with each level held for at least two `clk` cycles. Each action takes effect on the `clk` edge where the new level of its input is first seen.

Top module: `serial_result_mux`

## Requirements
- R1: After reset, `laneOe` and `laneData` are all zero.
- R2: A fall of `frameSync` enables the lanes that are active, and the first bit of each lane is driven at once. Lane straps and chain enable are latched at this point for the whole frame.
- R3: While `frameSync` is high, all `laneOe` bits are 0 and `laneData` is 0, which is high impedance at the pad.
- R4: Each word is sent MSB first. A lane moves to its next bit only on a rising edge of `serClk` inside a frame; at all other times its output holds.
- R5: `loadData` packs word i (0..5 = A0, A1, B0, B1, C0, C1) at bits [16i+15:16i]. With `selB`=1 and `selC`=1, lane A sends A0 A1, lane B sends B0 B1 and lane C sends C0 C1.
- R6: With `selB`=1 and `selC`=0, lane A sends A0 A1 C0 and lane B sends B0 B1 C1.
- R7: With `selB`=0 and `selC`=0, lane A alone sends A0 A1 B0 B1 C0 C1.
- R8: With `selB`=0 and `selC`=1, lane A sends A0 A1 B0 B1 and lane C sends C0 C1.
- R9: With `chainEn`=1, the bits on `chainIn[l]` (bit 0 = lane A, bit 1 = lane B, bit 2 = lane C) are sampled on each falling edge of `serClk` and follow that lane's local words in the same order.
- R10: With `chainEn`=0, a lane sends zeros after its local words.
- R11: A `loadStb` pulse during a frame does not change that frame's data. The new words are sent from the next frame on.
- R12: Inside a frame, lane A is always enabled, and lane B or lane C is enabled only if its strap was high at frame start. A lane that is switched off keeps `laneOe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame sync; a fall opens a frame, high closes it |
| serClk | input | 1 | Serial clock; idles high |
| selB | input | 1 | Lane B strap |
| selC | input | 1 | Lane C strap |
| chainEn | input | 1 | Daisy-chain enable |
| chainIn | input | 3 | Per-lane chain data input |
| loadStb | input | 1 | Captures `loadData` |
| loadData | input | 6*WORD_W | Six packed conversion results |
| laneData | output | 3 | Serial data per lane |
| laneOe | output | 3 | Output enable per lane (low = high impedance) |

## Verification
The hardest case to reach is a chained frame on a folded lane. There, the chain bits emerge only after up to 96 local bits, and each one was sampled on a falling edge long before it appears. The bench runs frames of 104 bits in every strap pattern, with chaining both on and off, so that chain bits reach even lane A when it carries all six words. For each lane it logs every chain bit it drives and compares each bit on the lane. A further frame sends a new load pulse mid-frame and then checks the next frame.

// File: rtl/serial_result_mux_pkg.sv
package serial_result_mux_pkg;
  localparam int NUM_LANES = 3;
  localparam int NUM_WORDS = 6;

  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic grabChain;
  } seqStrobes_t;

  typedef struct packed {
    logic useB;
    logic useC;
    logic chainOn;
  } laneCfg_t;

  // Number of words a lane carries for a given strap setting.
  function automatic int laneWords(laneCfg_t c, int lane);
    int n;
    n = 0;
    unique case ({c.useB, c.useC})
      2'b11: n = 2;
      2'b10: n = (lane == 2) ? 0 : 3;
      2'b01: n = (lane == 0) ? 4 : ((lane == 2) ? 2 : 0);
      default: n = (lane == 0) ? 6 : 0;
    endcase
    return n;
  endfunction

  // Result index (0..5 = A0 A1 B0 B1 C0 C1) sent in a given slot of a lane.
  function automatic int wordIndex(laneCfg_t c, int lane, int slot);
    int idx;
    if (lane == 0) idx = (c.useB && !c.useC && slot == 2) ? 4 : slot;
    else if (lane == 1) idx = (slot == 2) ? 5 : slot + 2;
    else idx = slot + 4;
    return idx;
  endfunction
endpackage

// File: rtl/serial_result_mux_ctrl.sv
module serial_result_mux_ctrl
  import serial_result_mux_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameSync,
  input  logic        serClk,
  input  logic        selB,
  input  logic        selC,
  input  logic        chainEn,
  output seqStrobes_t strb,
  output laneCfg_t    cfgLive,
  output laneCfg_t    cfgHeld,
  output logic [NUM_LANES-1:0] laneOe
);
  logic fsQ;
  logic sclkQ;
  logic frameFall;

  always_comb begin
    cfgLive.useB    = selB;
    cfgLive.useC    = selC;
    cfgLive.chainOn = chainEn;
    frameFall       = fsQ & ~frameSync;
    strb.loadFrame  = frameFall;
    strb.shiftBit   = laneOe[0] & ~frameSync & ~sclkQ & serClk;
    strb.grabChain  = laneOe[0] & ~frameSync & sclkQ & ~serClk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsQ     <= 1'b1;
      sclkQ   <= 1'b1;
      laneOe  <= '0;
      cfgHeld <= '0;
    end else begin
      fsQ   <= frameSync;
      sclkQ <= serClk;
      if (frameSync) begin
        laneOe <= '0;
      end else if (frameFall) begin
        laneOe  <= {selC, selB, 1'b1};
        cfgHeld <= cfgLive;
      end
    end
  end
endmodule

// File: rtl/serial_result_mux_path.sv
module serial_result_mux_path
  import serial_result_mux_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobes_t                 strb,
  input  laneCfg_t                    cfgLive,
  input  laneCfg_t                    cfgHeld,
  input  logic [NUM_LANES-1:0]        laneOe,
  input  logic                        loadStb,
  input  logic [NUM_WORDS*WORD_W-1:0] loadData,
  input  logic [NUM_LANES-1:0]        chainIn,
  output logic [NUM_LANES-1:0]        laneData
);
  localparam int SHIFT_W = NUM_WORDS * WORD_W;
  localparam int TAP_W   = $clog2(SHIFT_W);

  logic [SHIFT_W-1:0]   heldQ;
  logic [SHIFT_W-1:0]   image [NUM_LANES];
  logic [SHIFT_W-1:0]   shQ   [NUM_LANES];
  logic [NUM_LANES-1:0] chainQ;

  // Result store: loads at any time, copied into the lanes only at frame start.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ  <= '0;
      chainQ <= '0;
    end else begin
      if (loadStb) heldQ <= loadData;
      if (strb.grabChain) chainQ <= chainIn;
    end
  end

  // Lane images: local words right-justified, first word highest.
  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      int n;
      image[l] = '0;
      n = laneWords(cfgLive, l);
      for (int s = 0; s < NUM_WORDS; s++) begin
        if (s < n) begin
          image[l][(n - 1 - s) * WORD_W +: WORD_W] =
            heldQ[wordIndex(cfgLive, l, s) * WORD_W +: WORD_W];
        end
      end
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shQ[l] <= '0;
      end else if (strb.loadFrame) begin
        shQ[l] <= image[l];
      end else if (strb.shiftBit) begin
        shQ[l] <= {shQ[l][SHIFT_W-2:0], chainQ[l] & cfgHeld.chainOn};
      end
    end
  end

  // The tap sits at the top of the lane's local words, so chain bits trail them.
  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      int tap;
      tap = laneWords(cfgHeld, l) * WORD_W - 1;
      if (tap >= 0) laneData[l] = laneOe[l] & shQ[l][TAP_W'(tap)];
      else laneData[l] = 1'b0;
    end
  end
endmodule

// File: rtl/serial_result_mux.sv
module serial_result_mux
  import serial_result_mux_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameSync,
  input  logic                  serClk,
  input  logic                  selB,
  input  logic                  selC,
  input  logic                  chainEn,
  input  logic [2:0]            chainIn,
  input  logic                  loadStb,
  input  logic [6*WORD_W-1:0]   loadData,
  output logic [2:0]            laneData,
  output logic [2:0]            laneOe
);
  seqStrobes_t strb;
  laneCfg_t    cfgLive;
  laneCfg_t    cfgHeld;

  serial_result_mux_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameSync(frameSync),
    .serClk   (serClk),
    .selB     (selB),
    .selC     (selC),
    .chainEn  (chainEn),
    .strb     (strb),
    .cfgLive  (cfgLive),
    .cfgHeld  (cfgHeld),
    .laneOe   (laneOe)
  );

  serial_result_mux_path #(.WORD_W(WORD_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgLive (cfgLive),
    .cfgHeld (cfgHeld),
    .laneOe  (laneOe),
    .loadStb (loadStb),
    .loadData(loadData),
    .chainIn (chainIn),
    .laneData(laneData)
  );
endmodule

// File: rtl/serial_result_mux_chk.sv
module serial_result_mux_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameSync,
  input logic       serClk,
  input logic       selB,
  input logic       selC,
  input logic [2:0] laneData,
  input logic [2:0] laneOe
);
  // R3: a high frame sync seen on the previous edge leaves every lane off
  a_r3_idle_hiz: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameSync) |-> (laneOe == 3'b000 && laneData == 3'b000));

  // R2: a frame-sync fall enables lane A on the next edge
  a_r2_frame_open: assert property (@(posedge clk) disable iff (!rstN)
    ($past(frameSync) && !frameSync) |=> laneOe[0]);

  // R12: enabled lanes match the straps seen at frame start
  a_r12_lane_map: assert property (@(posedge clk) disable iff (!rstN)
    ($past(frameSync) && !frameSync) |=> (laneOe == {$past(selC), $past(selB), 1'b1}));

  // R12: lane B or C never enabled without lane A
  a_r12_lane_a_on: assert property (@(posedge clk) disable iff (!rstN)
    (laneOe[1] || laneOe[2]) |-> laneOe[0]);

  // R4: inside a frame, data holds unless the serial clock rose
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && !$past(frameSync) && !(serClk && !$past(serClk))) |=> $stable(laneData));
endmodule

bind serial_result_mux serial_result_mux_chk i_chk (.*);

// File: tb/test_serial_result_mux.sv
module test_serial_result_mux;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 104;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameSync = 1'b1;
  logic        serClk = 1'b1;
  logic        selB = 1'b1;
  logic        selC = 1'b1;
  logic        chainEn = 1'b0;
  logic [2:0]  chainIn = '0;
  logic        loadStb = 1'b0;
  logic [95:0] loadData = '0;
  logic [2:0]  laneData;
  logic [2:0]  laneOe;

  int testsRun = 0;
  int testsFailed = 0;
  logic [15:0] heldW [6];
  logic [15:0] frameW [6];
  logic chainLog [3][NB];

  serial_result_mux i_serial_result_mux (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    testsFailed++;
    $display("FAIL watchdog: run did not finish (act=timeout exp=done)");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] patWord(int p, int i);
    if (p == 1) return (i % 2 == 0) ? 16'h8001 : 16'hFFFE;
    return 16'h1D2B ^ 16'(i * 16'h3A65) ^ 16'(p * 16'h5A0F);
  endfunction

  task automatic loadPattern(int p);
    for (int i = 0; i < 6; i++) begin
      heldW[i] = patWord(p, i);
      loadData[16*i +: 16] = heldW[i];
    end
    loadStb = 1'b1;
    waitClk(1);
    loadStb = 1'b0;
  endtask

  // Words per lane and word order, taken from R5..R8
  function automatic int lenOf(int ub, int uc, int l);
    if (ub && uc) return 2;
    if (ub) return (l == 2) ? 0 : 3;
    if (uc) return (l == 0) ? 4 : ((l == 2) ? 2 : 0);
    return (l == 0) ? 6 : 0;
  endfunction

  function automatic int idxOf(int ub, int uc, int l, int s);
    if (l == 0) return (ub && !uc && s == 2) ? 4 : s;
    if (l == 1) return (s == 2) ? 5 : s + 2;
    return s + 4;
  endfunction

  task automatic runFrame(int ub, int uc, int ch, int midLoad, string tagLocal);
    selB = ub[0]; selC = uc[0]; chainEn = ch[0];
    frameSync = 1'b0;
    waitClk(2);
    for (int k = 0; k < NB; k++) begin
      for (int l = 0; l < 3; l++) begin
        int n;
        int e;
        int eo;
        n = lenOf(ub, uc, l);
        eo = (l == 0) || (l == 1 && ub != 0) || (l == 2 && uc != 0);
        chk("R12 lane enable", int'(laneOe[l]), eo);
        if (n == 0) begin
          chk("R12 deselected lane", int'(laneData[l]), 0);
        end else if (k < n * 16) begin
          e = int'(frameW[idxOf(ub, uc, l, k / 16)][15 - (k % 16)]);
          chk(tagLocal, int'(laneData[l]), e); // R4 bit order
        end else if (ch != 0) begin
          chk("R9 chain tail", int'(laneData[l]), int'(chainLog[l][k - n * 16]));
        end else begin
          chk("R10 zero tail", int'(laneData[l]), 0);
        end
      end
      for (int l = 0; l < 3; l++) begin
        chainLog[l][k] = (((k * 7 + l * 3 + ub * 5 + uc) % 5) < 2);
        chainIn[l] = chainLog[l][k];
      end
      serClk = 1'b0;
      if (midLoad != 0 && k == 20) loadPattern(2);
      waitClk(2);
      serClk = 1'b1;
      waitClk(2);
    end
    frameSync = 1'b1;
    waitClk(2);
    chk("R3 idle enable", int'(laneOe), 0);
    chk("R3 idle data", int'(laneData), 0);
  endtask

  initial begin
    waitClk(3);
    chk("R1 reset enable", int'(laneOe), 0);
    chk("R1 reset data", int'(laneData), 0);
    rstN = 1'b1;
    waitClk(2);
    chk("R3 idle after reset", int'(laneOe), 0);
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int p = 0; p < 2; p++) begin
          int ub;
          int uc;
          string t;
          ub = cfg / 2;
          uc = cfg % 2;
          t = (ub && uc) ? "R4/R5 routing" : (ub ? "R4/R6 routing" :
              (uc ? "R4/R8 routing" : "R4/R7 routing"));
          loadPattern(p);
          for (int i = 0; i < 6; i++) frameW[i] = heldW[i];
          runFrame(ub, uc, ch, 0, t);
        end
      end
    end
    // R11: reload during a frame, then check the following frame
    loadPattern(0);
    for (int i = 0; i < 6; i++) frameW[i] = heldW[i];
    runFrame(1, 1, 0, 1, "R11 old data kept");
    for (int i = 0; i < 6; i++) frameW[i] = heldW[i];
    runFrame(0, 0, 1, 0, "R11 new data next frame");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule